// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar in packed BCD: hundredths of a second, seconds, minutes, hours, day of the week, date, month and two-digit year. A single-cycle enable pulse at 100 Hz moves the time forward by one hundredth. Carries pass up the whole chain within that same clock cycle. The last date of each month depends on the month, and February gets a 29th in leap years.

Software, or a serial front end outside this block, reaches the eight 8-bit registers through a parallel port. That port has one write channel and one combinational read channel. The hours register holds a 12/24-hour select and an AM/PM flag. The day register holds a control bit that stops the clock and a control bit that masks the external reset request. Bits with no function are dropped on write, so they always read as zero.

Top module: `bcd_timekeeper`

## Requirements
- R1: After the synchronous active-low reset, the registers read, in address order 0 to 7: 00, 00, 00, 00, 01, 01, 01, 00 (hex).
- R2: Register addresses are 0 hundredths (00-99), 1 seconds (00-59), 2 minutes (00-59), 3 hours, 4 day of week (1-7), 5 date, 6 month (01-12) and 7 year (00-99). Each tick_100hz cycle adds one hundredth in BCD. Each field carries into the next one up in the same cycle.
- R3: Day register bit 5 set to 1 stops the clock, and ticks are ignored. Set to 0, the clock runs.
- R4: Hours bit 7 = 0 selects 24-hour mode, where bits 5:0 are BCD hours 00-23. 23 wraps to 00 and advances the day of week and the date.
- R5: Hours bit 7 = 1 selects 12-hour mode, where bit 5 = 1 means PM and bits 4:0 are BCD hours 01-12. The order is 11 AM, 12 PM, 01 PM, and 11 PM, 12 AM (next day), 01 AM.
- R6: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other 30/31-day months.
- R7: February ends at 29 when the year value is divisible by 4 (00 counts), and at 28 otherwise.
- R8: Day of week wraps from 7 to 1. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: Unused bits read 0 whatever was written. The stored masks are seconds 7F, minutes 7F, hours BF, day 37, date 3F and month 1F. Hundredths and year keep all 8 bits.
- R10: In a cycle where wr_en is high, the addressed register takes wr_data (masked) and a tick in that cycle is ignored for every field. The written value is readable on the next cycle.
- R11: abort_req is high exactly when ext_rst_n is low and day register bit 4 is 0. It follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable, one per hundredth of a second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for writes |
| wr_data | input | 8 | Value to write |
| rd_addr | input | 3 | Register index for reads |
| rd_data | output | 8 | Contents of the register at rd_addr |
| ext_rst_n | input | 1 | External active-low reset request |
| abort_req | output | 1 | Transfer abort request to the serial front end |

## Verification
A write or a tick is captured on the next rising edge. The result is readable on rd_data from that edge on, because the read path has no register. The bench drives each stimulus for exactly one cycle, from one falling edge to the next. It then samples at that next falling edge, one register stage after the stimulus. abort_req has no register, so the bench checks it in the same half-cycle in which ext_rst_n or the control bit changed. Each rollover case is set up by writing the fields just below their limits and then applying one tick.

// File: rtl/tk_pkg.sv
// Package: shared register indices and BCD helpers for the timekeeper.
// Assumes two-digit packed BCD fields held in 8-bit registers.
package tk_pkg;
    localparam int unsigned IDX_HUND  = 0;
    localparam int unsigned IDX_SEC   = 1;
    localparam int unsigned IDX_MIN   = 2;
    localparam int unsigned IDX_HOUR  = 3;
    localparam int unsigned IDX_DAY   = 4;
    localparam int unsigned IDX_DATE  = 5;
    localparam int unsigned IDX_MONTH = 6;
    localparam int unsigned IDX_YEAR  = 7;

    localparam int unsigned DAY_STOP_BIT  = 5;
    localparam int unsigned DAY_RMASK_BIT = 4;
    localparam int unsigned HR_MODE12_BIT = 7;
    localparam int unsigned HR_PM_BIT     = 5;

    // Add one to a two-digit packed BCD value (no range check).
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Bits that carry meaning in each register; the rest are stored as zero.
    function automatic logic [7:0] field_mask(input logic [2:0] idx);
        case (idx)
            3'd1, 3'd2: return 8'h7F;
            3'd3:       return 8'hBF;
            3'd4:       return 8'h37;
            3'd5:       return 8'h3F;
            3'd6:       return 8'h1F;
            default:    return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/tk_bcd_field.sv
// Module: one two-digit BCD counting field.
// Steps cur when step is high; at or above lim it returns to MINV and raises carry.
// Assumes cur and lim are valid BCD.
module tk_bcd_field #(
    parameter logic [7:0] MINV = 8'h00
) (
    input  logic [7:0] cur,
    input  logic [7:0] lim,
    input  logic       step,
    output logic [7:0] nxt,
    output logic       carry
);
    // Compute the next value and the carry into the next field.
    always_comb begin
        carry = step && (cur >= lim);
        if (!step)
            nxt = cur;
        else if (cur >= lim)
            nxt = MINV;
        else
            nxt = tk_pkg::bcd_inc8(cur);
    end
endmodule

// File: rtl/tk_hour_step.sv
// Module: next hours value in 12- or 24-hour form.
// Keeps the mode bit and raises day_carry at midnight.
// Assumes the hours register has already been masked (bit 6 zero).
module tk_hour_step (
    input  logic [7:0] hr,
    input  logic       step,
    output logic [7:0] nxt,
    output logic       day_carry
);
    logic       mode12;
    logic       pm;
    logic [7:0] h12;
    logic [7:0] h24;
    logic [7:0] h24_inc;

    assign mode12  = hr[tk_pkg::HR_MODE12_BIT];
    assign pm      = hr[tk_pkg::HR_PM_BIT];
    assign h12     = {3'b000, hr[4:0]};
    assign h24     = {2'b00, hr[5:0]};
    assign h24_inc = tk_pkg::bcd_inc8(h24);

    // Select the next hour and the midnight carry for the active mode.
    always_comb begin
        nxt       = hr;
        day_carry = 1'b0;
        if (step) begin
            if (mode12) begin
                if (h12 >= 8'h12) begin
                    nxt = {1'b1, 1'b0, pm, 5'h01};
                end else if (h12 == 8'h11) begin
                    nxt       = {1'b1, 1'b0, ~pm, 5'h12};
                    day_carry = pm;
                end else begin
                    nxt = {1'b1, 1'b0, pm, tk_pkg::bcd_inc8(h12)[4:0]};
                end
            end else begin
                if (h24 >= 8'h23) begin
                    nxt       = 8'h00;
                    day_carry = 1'b1;
                end else begin
                    nxt = {2'b00, h24_inc[5:0]};
                end
            end
        end
    end
endmodule

// File: rtl/tk_month_len.sv
// Module: last date (BCD) of a month, with the leap rule on the two-digit year.
// Assumes a BCD month 01-12 and a BCD year 00-99.
module tk_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    assign year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    assign leap     = (year_bin[1:0] == 2'b00);

    // Map the month to its length.
    always_comb begin
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_timekeeper.sv
// Module: BCD clock/calendar with a parallel register port.
// Advances by one hundredth on each tick while the stop bit is clear.
// A write in the same cycle wins over the tick. Unused bits are stored as zero.
// Assumes tick_100hz is a one-cycle pulse in the clk domain.
module bcd_timekeeper #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned REG_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_100hz,
    input  logic                      wr_en,
    input  logic [$clog2(NREG)-1:0]   wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [$clog2(NREG)-1:0]   rd_addr,
    output logic [REG_W-1:0]          rd_data,
    input  logic                      ext_rst_n,
    output logic                      abort_req
);
    import tk_pkg::*;

    localparam int unsigned ADDR_W = $clog2(NREG);

    logic [NREG-1:0][REG_W-1:0] regs_q;
    logic [NREG-1:0][REG_W-1:0] regs_n;

    logic       adv;
    logic       c_sec, c_min, c_hour, c_day, c_date, c_month, c_unused;
    logic [7:0] hund_n, sec_n, min_n, hour_n, date_n, month_n, year_n;
    logic [7:0] last_date;
    logic [7:0] dow;

    assign adv = tick_100hz && !wr_en && !regs_q[IDX_DAY][DAY_STOP_BIT];

    tk_bcd_field #(.MINV(8'h00)) u_hund (
        .cur(regs_q[IDX_HUND]), .lim(8'h99), .step(adv),
        .nxt(hund_n), .carry(c_sec));
    tk_bcd_field #(.MINV(8'h00)) u_sec (
        .cur(regs_q[IDX_SEC]), .lim(8'h59), .step(c_sec),
        .nxt(sec_n), .carry(c_min));
    tk_bcd_field #(.MINV(8'h00)) u_min (
        .cur(regs_q[IDX_MIN]), .lim(8'h59), .step(c_min),
        .nxt(min_n), .carry(c_hour));
    tk_hour_step u_hour (
        .hr(regs_q[IDX_HOUR]), .step(c_hour),
        .nxt(hour_n), .day_carry(c_day));
    tk_month_len u_mlen (
        .month(regs_q[IDX_MONTH]), .year(regs_q[IDX_YEAR]),
        .last_date(last_date));
    tk_bcd_field #(.MINV(8'h01)) u_date (
        .cur(regs_q[IDX_DATE]), .lim(last_date), .step(c_day),
        .nxt(date_n), .carry(c_date));
    tk_bcd_field #(.MINV(8'h01)) u_month (
        .cur(regs_q[IDX_MONTH]), .lim(8'h12), .step(c_date),
        .nxt(month_n), .carry(c_month));
    tk_bcd_field #(.MINV(8'h00)) u_year (
        .cur(regs_q[IDX_YEAR]), .lim(8'h99), .step(c_month),
        .nxt(year_n), .carry(c_unused));

    // Day of week: wrap 7 to 1 on a date change, keeping the control bits.
    always_comb begin
        dow = regs_q[IDX_DAY];
        if (c_day)
            dow[2:0] = (regs_q[IDX_DAY][2:0] >= 3'd7) ? 3'd1 : regs_q[IDX_DAY][2:0] + 3'd1;
    end

    // Gather the next state of all fields for a tick cycle.
    always_comb begin
        regs_n            = regs_q;
        regs_n[IDX_HUND]  = hund_n;
        regs_n[IDX_SEC]   = sec_n;
        regs_n[IDX_MIN]   = min_n;
        regs_n[IDX_HOUR]  = hour_n;
        regs_n[IDX_DAY]   = dow;
        regs_n[IDX_DATE]  = date_n;
        regs_n[IDX_MONTH] = month_n;
        regs_n[IDX_YEAR]  = year_n;
    end

    // Register update: reset, then a masked write, otherwise the counted value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q            <= '0;
            regs_q[IDX_DAY]   <= 8'h01;
            regs_q[IDX_DATE]  <= 8'h01;
            regs_q[IDX_MONTH] <= 8'h01;
        end else if (wr_en) begin
            regs_q[wr_addr] <= wr_data & field_mask(3'(wr_addr));
        end else begin
            regs_q <= regs_n;
        end
    end

    assign rd_data   = regs_q[rd_addr];
    assign abort_req = !ext_rst_n && !regs_q[IDX_DAY][DAY_RMASK_BIT];

    logic [ADDR_W-1:0] unused_addr_w;
    assign unused_addr_w = '0;
endmodule

// File: rtl/tk_checker.sv
// Module: assertions for bcd_timekeeper, attached with bind.
// Observes the ports and the register array of the top module.
module tk_checker #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned REG_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_100hz,
    input logic                      wr_en,
    input logic [$clog2(NREG)-1:0]   wr_addr,
    input logic [REG_W-1:0]          wr_data,
    input logic [$clog2(NREG)-1:0]   rd_addr,
    input logic [REG_W-1:0]          rd_data,
    input logic                      ext_rst_n,
    input logic                      abort_req,
    input logic [NREG-1:0][REG_W-1:0] regs
);
    AST_NO_ABORT_WHEN_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_n |-> !abort_req); // R11

    AST_STOP_HOLDS_HUND: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[4][5] && !wr_en) |=> $stable(regs[0])); // R3

    AST_LOAD_WINS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 0 && tick_100hz) |=> (regs[0] == $past(wr_data))); // R10

    AST_HUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz && !wr_en && !regs[4][5] && regs[0] == 8'h99) |=> (regs[0] == 8'h00)); // R2

    AST_SEC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 1) |-> !rd_data[7]); // R9
endmodule

bind bcd_timekeeper tk_checker #(.NREG(NREG), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_rst_n(ext_rst_n), .abort_req(abort_req), .regs(regs_q));

// File: tb/bcd_timekeeper_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module bcd_timekeeper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_rst_n = 1'b1;
    logic       abort_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bcd_timekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_rst_n(ext_rst_n), .abort_req(abort_req));

    // Drive one cycle of stimulus from falling edge to falling edge.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; tick_100hz = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_100hz = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tick1();
        cyc(1'b0, 3'd0, 8'h00, 1'b1);
    endtask

    // Put hundredths, seconds and minutes one tick below the hour carry.
    task automatic pre_hour();
        wr(3'd0, 8'h99); wr(3'd1, 8'h59); wr(3'd2, 8'h59);
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_abort(input logic exp, input string tag);
        #1;
        n_chk++;
        if (abort_req !== exp) begin
            n_fail++;
            $display("FAIL %s abort_req actual=%b expected=%b", tag, abort_req, exp);
        end
    endtask

    task automatic t_reset();
        chk_reg(0, 8'h00, "R1"); chk_reg(1, 8'h00, "R1"); chk_reg(2, 8'h00, "R1");
        chk_reg(3, 8'h00, "R1"); chk_reg(4, 8'h01, "R1"); chk_reg(5, 8'h01, "R1");
        chk_reg(6, 8'h01, "R1"); chk_reg(7, 8'h00, "R1");
        chk_abort(1'b0, "R1");
    endtask

    task automatic t_count();
        wr(3'd0, 8'h98); tick1();
        chk_reg(0, 8'h99, "R2"); chk_reg(1, 8'h00, "R2");
        tick1();
        chk_reg(0, 8'h00, "R2"); chk_reg(1, 8'h01, "R2");
        pre_hour(); tick1();
        chk_reg(0, 8'h00, "R2"); chk_reg(1, 8'h00, "R2");
        chk_reg(2, 8'h00, "R2"); chk_reg(3, 8'h01, "R2");
    endtask

    task automatic t_stop();
        wr(3'd0, 8'h40); wr(3'd4, 8'h21); tick1(); tick1();
        chk_reg(0, 8'h40, "R3"); chk_reg(4, 8'h21, "R3");
        wr(3'd4, 8'h01); tick1();
        chk_reg(0, 8'h41, "R3");
    endtask

    task automatic t_24h();
        wr(3'd4, 8'h03); wr(3'd5, 8'h10); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(3, 8'h00, "R4"); chk_reg(4, 8'h04, "R4"); chk_reg(5, 8'h11, "R4");
    endtask

    task automatic t_12h();
        wr(3'd3, 8'h91); pre_hour(); tick1();
        chk_reg(3, 8'hB2, "R5"); chk_reg(4, 8'h04, "R5");
        pre_hour(); tick1();
        chk_reg(3, 8'hA1, "R5");
        wr(3'd3, 8'hB1); pre_hour(); tick1();
        chk_reg(3, 8'h92, "R5"); chk_reg(4, 8'h05, "R5"); chk_reg(5, 8'h12, "R5");
        pre_hour(); tick1();
        chk_reg(3, 8'h81, "R5");
    endtask

    task automatic t_months();
        wr(3'd6, 8'h04); wr(3'd5, 8'h30); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h01, "R6"); chk_reg(6, 8'h05, "R6");
        wr(3'd5, 8'h30); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h31, "R6"); chk_reg(6, 8'h05, "R6");
    endtask

    task automatic t_feb();
        wr(3'd7, 8'h24); wr(3'd6, 8'h02); wr(3'd5, 8'h28); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h29, "R7"); chk_reg(6, 8'h02, "R7");
        wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h01, "R7"); chk_reg(6, 8'h03, "R7");
        wr(3'd7, 8'h23); wr(3'd6, 8'h02); wr(3'd5, 8'h28); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h01, "R7"); chk_reg(6, 8'h03, "R7");
        wr(3'd7, 8'h00); wr(3'd6, 8'h02); wr(3'd5, 8'h28); wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(5, 8'h29, "R7");
    endtask

    task automatic t_wraps();
        wr(3'd4, 8'h07); wr(3'd7, 8'h99); wr(3'd6, 8'h12); wr(3'd5, 8'h31);
        wr(3'd3, 8'h23); pre_hour(); tick1();
        chk_reg(4, 8'h01, "R8"); chk_reg(5, 8'h01, "R8");
        chk_reg(6, 8'h01, "R8"); chk_reg(7, 8'h00, "R8");
    endtask

    task automatic t_mask();
        wr(3'd1, 8'hFF); chk_reg(1, 8'h7F, "R9");
        wr(3'd2, 8'hFF); chk_reg(2, 8'h7F, "R9");
        wr(3'd3, 8'hFF); chk_reg(3, 8'hBF, "R9");
        wr(3'd4, 8'hFF); chk_reg(4, 8'h37, "R9");
        wr(3'd5, 8'hFF); chk_reg(5, 8'h3F, "R9");
        wr(3'd6, 8'hFF); chk_reg(6, 8'h1F, "R9");
        wr(3'd7, 8'hFF); chk_reg(7, 8'hFF, "R9");
        wr(3'd4, 8'h01); wr(3'd3, 8'h00);
    endtask

    task automatic t_load_wins();
        wr(3'd0, 8'h20);
        cyc(1'b1, 3'd1, 8'h10, 1'b1);
        chk_reg(0, 8'h20, "R10"); chk_reg(1, 8'h10, "R10");
        cyc(1'b1, 3'd0, 8'h50, 1'b1);
        chk_reg(0, 8'h50, "R10");
    endtask

    task automatic t_abort();
        wr(3'd4, 8'h11);
        ext_rst_n = 1'b0; chk_abort(1'b0, "R11");
        wr(3'd4, 8'h01); chk_abort(1'b1, "R11");
        ext_rst_n = 1'b1; chk_abort(1'b0, "R11");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_stop();
        t_24h();
        t_12h();
        t_months();
        t_feb();
        t_wraps();
        t_mask();
        t_load_wins();
        t_abort();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule